// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the level-sensitive INTx pins of a small set of PCI device slots and folds them onto four shared interrupt request lines. Each slot's pins are rotated by its slot number, so the same pin on neighbouring slots lands on different shared lines. Each shared line then goes through its own byte-wide steering register. That register either names one input of a legacy interrupt controller bank or disables the line. Every controller input is driven as the wired-OR of the shared lines steered to it.

Internally the block keeps one level bit for each pair of controller input and shared line. A shared line that changes level rewrites only its own bit and re-drives only the output it is steered to. A write that touches any steering byte clears the whole bitmap, re-samples all four line levels under the new steering and re-drives every output. A restore input rebuilds the bitmap from the present levels and holds the outputs frozen, so that restored interrupt controller state is not disturbed. A small two-phase machine, RUN and QUIET, tracks whether a restore is in progress. Each cycle is classified as one of four events: IDLE, TRACK, REMAP or HOLD.

Top module: `pirq_router`

## Requirements
- R1: The pin bit `dev_intx_i[s*4+p]` belongs to pin p (0..3) of the device in slot number FIRST_SLOT+s. It drives shared line number (p + slot number - 1) mod 4. With the defaults, slot index s adds s to the pin number.
- R2: The steering bytes for shared lines 0..3 sit at byte addresses 0x60..0x63. Line k's byte is carried in data bits 8k+7..8k and enabled by `cfg_be_i[k]`, in the double word at 0x60. When `cfg_rd_addr_i` selects that double word, `cfg_rdata_o` returns the four bytes exactly as written, line 0 in the low byte. Any other double word reads 0. The bytes change only on a write.
- R3: After reset, every steering byte reads 0x80 and every `irq_o` bit is 0.
- R4: A steering byte below NUM_OUT (16) steers its line to `irq_o[value]`. A value of 16 to 255 disables the line, which then affects no output.
- R5: `irq_o[o]` is 1 when at least one enabled line steered to o is at level 1.
- R6: A change of level on a shared line is visible on the output it is steered to one clock edge after the pins are sampled. With no write, no restore and no pin change, the outputs hold.
- R7: A write updates only the bytes whose byte enable is set. A write to another double word, or with all byte enables clear, changes no steering byte and no output.
- R8: A write that enables any steering byte re-drives every output one edge later. Each output then equals the OR of the current levels of the lines steered to it under the new bytes.
- R9: While `restore_i` is high, `irq_o` holds. In the first restore cycle the bitmap is rebuilt from the current levels. After `restore_i` falls, an output changes only when a line steered to it changes level or a steering write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_intx_i | input | NUM_SLOTS*4 | INTx levels, four pins per slot |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Write byte address (double-word aligned) |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rd_addr_i | input | ADDR_W | Read byte address (double-word aligned) |
| cfg_rdata_o | output | 32 | Read data, combinational |
| restore_i | input | 1 | State restore: rebuild bitmap, hold outputs |
| irq_o | output | NUM_OUT | Controller input levels, registered |

## Verification
Every registered result is due one rising edge after the stimulus that causes it: output changes from a pin change, re-driving after a steering write, and holding under restore. Read data follows the steering bytes combinationally, so a written byte is visible right after the edge that stores it. The bench drives inputs on falling edges. It updates its arithmetic model at the following rising edge and compares every output and read value at the next falling edge, one edge after each stimulus. The restore sequence checks stale outputs on purpose, cycle by cycle, to show which edges may and may not re-drive them.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
    localparam int LINES = 4;
    localparam int RB_W  = 8;

    typedef logic [LINES-1:0][RB_W-1:0] route_vec_t;

    typedef enum logic [0:0] {
        PH_RUN   = 1'b0,
        PH_QUIET = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_TRACK = 2'd1,
        EV_REMAP = 2'd2,
        EV_HOLD  = 2'd3
    } event_e;
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 1
) (
    input  logic [NUM_SLOTS*LINES-1:0] intx_i,
    output logic [LINES-1:0]           line_o
);
    // Per-slot rotated copies, OR-reduced below.
    logic [NUM_SLOTS-1:0][LINES-1:0] rot;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < LINES; p++) begin : g_pin
            localparam int TGT = (p + FIRST_SLOT + s + LINES - 1) % LINES;
            assign rot[s][TGT] = intx_i[s*LINES + p];
        end
    end

    always_comb begin
        line_o = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            line_o = line_o | rot[s];
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int ROUTE_BASE  = 'h60,
    parameter int ROUTE_RESET = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LINES-1:0]  be_i,
    input  logic [31:0]       wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rdata_o,
    output logic              hit_o,
    output route_vec_t        route_nxt_o,
    output route_vec_t        route_q_o
);
    localparam logic [ADDR_W-3:0] BASE_DW = (ADDR_W-2)'(ROUTE_BASE >> 2);
    localparam logic [RB_W-1:0]   RST_VAL = RB_W'(ROUTE_RESET);

    route_vec_t route_q;

    assign hit_o = wr_i && (addr_i[ADDR_W-1:2] == BASE_DW) && (|be_i);

    always_comb begin
        for (int b = 0; b < LINES; b++) begin
            route_nxt_o[b] = (hit_o && be_i[b]) ? wdata_i[8*b +: 8] : route_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < LINES; b++) begin
                route_q[b] <= RST_VAL;
            end
        end else begin
            route_q <= route_nxt_o;
        end
    end

    assign rdata_o   = (rd_addr_i[ADDR_W-1:2] == BASE_DW) ? route_q : 32'h0;
    assign route_q_o = route_q;
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   line_i,
    input  route_vec_t         route_i,
    input  logic               rebuild_i,
    output logic [NUM_OUT-1:0] drive_o,
    output logic [NUM_OUT-1:0] col_o
);
    localparam int BITS = NUM_OUT * LINES;

    logic [BITS-1:0]  bmp_q, bmp_nxt;
    logic [LINES-1:0] prev_q, chg, en;

    assign chg = line_i ^ prev_q;

    always_comb begin
        for (int k = 0; k < LINES; k++) begin
            en[k] = route_i[k] < RB_W'(NUM_OUT);
        end
    end

    // Bitmap: full rebuild, or each changed line rewrites its own bit.
    always_comb begin
        bmp_nxt = rebuild_i ? '0 : bmp_q;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int k = 0; k < LINES; k++) begin
                if (en[k] && route_i[k] == RB_W'(o) && (rebuild_i || chg[k])) begin
                    bmp_nxt[o*LINES + k] = line_i[k];
                end
            end
        end
    end

    // Outputs touched by a tracked level change.
    always_comb begin
        drive_o = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int k = 0; k < LINES; k++) begin
                if (chg[k] && route_i[k] == RB_W'(o)) begin
                    drive_o[o] = 1'b1;
                end
            end
            col_o[o] = |bmp_nxt[o*LINES +: LINES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bmp_q  <= '0;
            prev_q <= '0;
        end else begin
            bmp_q  <= bmp_nxt;
            prev_q <= line_i;
        end
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int FIRST_SLOT  = 1,
    parameter int NUM_OUT     = 16,
    parameter int ADDR_W      = 8,
    parameter int ROUTE_BASE  = 'h60,
    parameter int ROUTE_RESET = 'h80
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS*LINES-1:0] dev_intx_i,
    input  logic                       cfg_wr_i,
    input  logic [ADDR_W-1:0]          cfg_addr_i,
    input  logic [3:0]                 cfg_be_i,
    input  logic [31:0]                cfg_wdata_i,
    input  logic [ADDR_W-1:0]          cfg_rd_addr_i,
    output logic [31:0]                cfg_rdata_o,
    input  logic                       restore_i,
    output logic [NUM_OUT-1:0]         irq_o
);
    logic [LINES-1:0]   line_lvl;
    logic               cfg_hit, rebuild;
    route_vec_t         route_nxt, route_q;
    logic [NUM_OUT-1:0] drive, col;
    logic [NUM_OUT-1:0] irq_q;
    phase_e             phase_q, phase_nxt;
    event_e             ev;

    pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_swz (
        .intx_i (dev_intx_i),
        .line_o (line_lvl)
    );

    pirq_route_regs #(
        .ADDR_W(ADDR_W), .ROUTE_BASE(ROUTE_BASE), .ROUTE_RESET(ROUTE_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (cfg_wr_i),
        .addr_i      (cfg_addr_i),
        .be_i        (cfg_be_i),
        .wdata_i     (cfg_wdata_i),
        .rd_addr_i   (cfg_rd_addr_i),
        .rdata_o     (cfg_rdata_o),
        .hit_o       (cfg_hit),
        .route_nxt_o (route_nxt),
        .route_q_o   (route_q)
    );

    pirq_level_map #(.NUM_OUT(NUM_OUT)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_lvl),
        .route_i   (route_nxt),
        .rebuild_i (rebuild),
        .drive_o   (drive),
        .col_o     (col)
    );

    // Rebuild on a steering write, or on entry into a restore.
    assign rebuild = cfg_hit || (restore_i && phase_q == PH_RUN);

    // Phase transitions: ENTER (RUN->QUIET), STAY, LEAVE (QUIET->RUN).
    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_RUN:   if (restore_i)  phase_nxt = PH_QUIET;
            PH_QUIET: if (!restore_i) phase_nxt = PH_RUN;
            default:  phase_nxt = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_RUN;
        else        phase_q <= phase_nxt;
    end

    always_comb begin
        if (restore_i)     ev = EV_HOLD;
        else if (cfg_hit)  ev = EV_REMAP;
        else if (|drive)   ev = EV_TRACK;
        else               ev = EV_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            unique case (ev)
                EV_IDLE:  irq_q <= irq_q;
                EV_TRACK: irq_q <= (irq_q & ~drive) | (col & drive);
                EV_REMAP: irq_q <= col;
                EV_HOLD:  irq_q <= irq_q;
                default:  irq_q <= irq_q;
            endcase
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_OUT   = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLOTS*LINES-1:0] dev_intx_i,
    input logic                       cfg_wr_i,
    input logic                       cfg_hit,
    input logic                       restore_i,
    input logic [LINES-1:0]           line_lvl,
    input route_vec_t                 route_q,
    input logic [NUM_OUT-1:0]         irq_o
);
    logic [LINES-1:0]   lvl_d;
    logic               all_dis;
    logic [NUM_OUT-1:0] want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= line_lvl;
    end

    always_comb begin
        all_dis = 1'b1;
        want    = '0;
        for (int k = 0; k < LINES; k++) begin
            if (route_q[k] < RB_W'(NUM_OUT)) begin
                all_dis = 1'b0;
                if (lvl_d[k]) want[route_q[k][$clog2(NUM_OUT)-1:0]] = 1'b1;
            end
        end
    end

    AST_HOLD_ON_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> irq_o == $past(irq_o)); // R9

    AST_ROUTE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(route_q)); // R2

    AST_REMAP_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && !restore_i) |=> irq_o == want); // R8

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && !restore_i) |=> (!all_dis || irq_o == '0)); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_i && !restore_i && dev_intx_i == $past(dev_intx_i)) |=> $stable(irq_o)); // R6
endmodule

bind pirq_router pirq_router_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_OUT(NUM_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_intx_i (dev_intx_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_hit    (cfg_hit),
    .restore_i  (restore_i),
    .line_lvl   (line_lvl),
    .route_q    (route_q),
    .irq_o      (irq_o)
);

// File: tb/pirq_router_test.sv
module pirq_router_test;
    localparam int NS = 4;
    localparam int NO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS*4-1:0] dev = '0;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0;
    logic [7:0]    rd_addr = 8'h60;
    logic [31:0]   rdata;
    logic          restore = 1'b0;
    logic [NO-1:0] irq;

    int errors = 0;
    int checks = 0;

    // Bench model state
    logic [3:0][7:0] m_route;
    logic [NO*4-1:0] m_bmp;
    logic [3:0]      m_prev;
    logic [NO-1:0]   m_out;
    logic            m_quiet;

    pirq_router uut (
        .clk(clk), .rst_n(rst_n), .dev_intx_i(dev), .cfg_wr_i(wr),
        .cfg_addr_i(addr), .cfg_be_i(be), .cfg_wdata_i(wdata),
        .cfg_rd_addr_i(rd_addr), .cfg_rdata_o(rdata),
        .restore_i(restore), .irq_o(irq)
    );

    always #5 clk = ~clk;

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // R1: slot index s, pin p -> line (p + s + 1 - 1) mod 4 with first slot 1
    function automatic logic [3:0] lines_of(logic [NS*4-1:0] d);
        logic [3:0] r = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (d[s*4+p]) r[(p + s) % 4] = 1'b1;
        return r;
    endfunction

    task automatic model_edge();
        logic [3:0] lvl, chg;
        logic [3:0][7:0] rn;
        logic hit, rebuild;
        logic [NO-1:0] drv;
        lvl = lines_of(dev);
        chg = lvl ^ m_prev;
        hit = wr && addr[7:2] == 6'h18 && be != 4'h0;
        for (int b = 0; b < 4; b++) rn[b] = (hit && be[b]) ? wdata[8*b +: 8] : m_route[b];
        rebuild = hit || (restore && !m_quiet);
        drv = '0;
        if (rebuild) m_bmp = '0;
        for (int k = 0; k < 4; k++) begin
            if (int'(rn[k]) < NO) begin
                if (rebuild || chg[k]) m_bmp[int'(rn[k])*4 + k] = lvl[k];
                if (chg[k]) drv[int'(rn[k])] = 1'b1;
            end
        end
        if (!restore) begin
            for (int o = 0; o < NO; o++)
                if (hit || drv[o]) m_out[o] = |m_bmp[o*4 +: 4];
        end
        m_quiet = restore;
        m_prev  = lvl;
        m_route = rn;
    endtask

    task automatic check_out(string tag);
        checks++;
        if (irq !== m_out) begin
            errors++;
            $display("FAIL %s: irq actual=%h expected=%h", tag, irq, m_out);
        end
    endtask

    task automatic check_rd(string tag, logic [7:0] a, logic [31:0] exp);
        rd_addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata actual=%h expected=%h", tag, rdata, exp);
        end
        rd_addr = 8'h60;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr = 1'b0;
        check_out(tag);
    endtask

    task automatic cfg_write(logic [7:0] a, logic [3:0] e, logic [31:0] d, string tag);
        wr = 1'b1; addr = a; be = e; wdata = d;
        step(tag);
    endtask

    initial begin
        for (int b = 0; b < 4; b++) m_route[b] = 8'h80;
        m_bmp = '0; m_prev = '0; m_out = '0; m_quiet = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset values
        check_out("R3 reset outputs");
        check_rd("R3 reset bytes", 8'h60, 32'h80808080);

        // R1 R4 R6: every pin of every slot against 16 rotating targets
        for (int t = 0; t < 16; t++) begin
            cfg_write(8'h60, 4'hF, {8'((t+3)%16), 8'((t+2)%16), 8'((t+1)%16), 8'(t)}, "R8 route write");
            for (int s = 0; s < NS; s++) begin
                for (int p = 0; p < 4; p++) begin
                    dev = '0; dev[s*4+p] = 1'b1;
                    step("R1 pin swizzle");
                    checks++;
                    if (irq !== (16'h1 << ((t + (p + s) % 4) % 16))) begin
                        errors++;
                        $display("FAIL R1 direct: irq actual=%h expected=%h", irq,
                                 16'h1 << ((t + (p + s) % 4) % 16));
                    end
                    dev = '0;
                    step("R6 level drop");
                end
            end
        end

        // R4: enabled and disabled byte values on line 0 with its pin held high
        dev = 16'h0001;
        step("R6 raise line 0");
        foreach (m_out[i]) begin end
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v;
            case (i)
                0: v = 8'h0F; 1: v = 8'h10; 2: v = 8'h00;
                3: v = 8'h7F; 4: v = 8'h05; default: v = 8'hFF;
            endcase
            cfg_write(8'h60, 4'h1, {24'h0, v}, "R4 enable or disable");
        end
        // R4: all disabled -> all low
        cfg_write(8'h60, 4'hF, 32'h80FF1020, "R4 all disabled");

        // R5: four lines to output 5, raise and drop one by one
        cfg_write(8'h60, 4'hF, 32'h05050505, "R8 all to 5");
        for (int k = 0; k < 4; k++) begin dev[k] = 1'b1; step("R5 wired-OR raise"); end
        for (int k = 0; k < 4; k++) begin dev[k] = 1'b0; step("R5 wired-OR drop"); end

        // R7: partial writes and ignored writes
        cfg_write(8'h60, 4'b0101, 32'h11223344, "R7 partial write");
        check_rd("R7 partial bytes", 8'h60, 32'h05220544);
        cfg_write(8'h64, 4'hF, 32'h00000000, "R7 other dword");
        cfg_write(8'h60, 4'h0, 32'h00000000, "R7 no enables");
        check_rd("R7 bytes unchanged", 8'h60, 32'h05220544);
        check_rd("R2 other address", 8'h5C, 32'h0);
        cfg_write(8'h60, 4'hF, 32'hDEAD0B03, "R2 write");
        check_rd("R2 readback", 8'h60, 32'hDEAD0B03);

        // R9: restore holds outputs and leaves them stale afterwards
        cfg_write(8'h60, 4'hF, 32'h80800303, "R8 lines 0,1 to 3");
        restore = 1'b1;
        step("R9 restore entry");
        dev[0] = 1'b1;
        step("R9 hold while restoring");
        step("R9 hold");
        restore = 1'b0;
        step("R9 stale after release");
        checks++;
        if (irq[3] !== 1'b0) begin
            errors++;
            $display("FAIL R9 stale: irq3 actual=%b expected=0", irq[3]);
        end
        dev[1] = 1'b1;
        step("R9 event re-drives");
        dev[1] = 1'b0;
        step("R9 bitmap kept line 0");
        checks++;
        if (irq[3] !== 1'b1) begin
            errors++;
            $display("FAIL R9 rebuilt: irq3 actual=%b expected=1", irq[3]);
        end
        dev = '0;
        step("R6 final drop");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule